// File: doc/BRIEF.md
# Bit-serial MDIO management master

This block is a management-interface master that reads and writes 16-bit registers in an external PHY over a two-wire serial link. The two wires are a management clock (MDC) and a bidirectional data line (MDIO), which is split here into an output, an output enable and an input. A host issues one request at a time on a valid/ready port. Each request carries a read/write flag, a 5-bit PHY address, a register address and the write data. The block shifts out the frame and returns a one-cycle response pulse. For a read, the register contents travel with that pulse.

Every transaction opens with a run of ones that lets the PHY find sync. The header or write frame follows, most significant bit first. After that the master releases the line. A read samples the PHY during a turnaround-plus-data-plus-idle window. A write only clocks two idle periods. A programmable half-period divider sets the MDC rate. The integrator picks the divider so that MDC stays at or below 2.5 MHz.

If the register address has any bit set above bit 4, the request is refused without touching the bus.

Back-pressure on the request port is simple. `req_ready` is high only while the block is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it comes.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `mdc` is low, `mdio_oe` is low, `busy` is low and `req_ready` is high.
- R2: Every accepted in-range transaction starts with 33 MDC bit periods in which `mdio_oe` is high and `mdio_o` is 1.
- R3: A read then drives 16 header bits, MSB first, equal to bits 15:0 of (0xF6 << 10) | (phy << 5) | reg. This is the pattern 11, 01, 10, then the 5 PHY address bits, then the 5 register address bits.
- R4: A write then drives 32 bits, MSB first, equal to 0x50020000 | (phy << 23) | (reg << 18) | data.
- R5: After a read header, `mdio_oe` stays low for 19 bit periods, and one MDIO sample is taken per period. Samples 1, 2 and 19 are discarded. Samples 3 to 18 form `rsp_rdata`, bit 15 first.
- R6: After a write frame, `mdio_oe` stays low for 2 further bit periods. The response to a write carries `rsp_rdata` = 0.
- R7: Each bit period is a low half followed by a high half. Each half lasts max(`cfg_half_div`, 2) clock cycles. `mdio_o` and `mdio_oe` change only where MDC falls.
- R8: A request whose `req_reg` has any bit set above bit 4 produces no MDC edge and no drive on MDIO. Its response pulse comes in the cycle after acceptance, with `rsp_rdata` = 0xFFFF for a read and 0 for a write.
- R9: `busy` is high and `req_ready` is low from acceptance through the response pulse. A request presented during that time is not taken.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long. For an in-range request the pulse follows the last bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_div | input | DIV_W | Clock cycles per MDC half period (values below 2 act as 2) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_IN_W | Register address; only values 0 to 31 are legal |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_valid` |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The situation hardest to reach from the ports is a read in which the PHY puts arbitrary values on the turnaround samples and on the trailing idle sample. These must be dropped while the sixteen data samples between them are kept in order. The bench models the PHY on MDC rising edges. It counts bit periods itself and places random noise on every sample outside the data window, so a window that is off by one produces a wrong word. Two further cases are forced by directed tests: a second request held on the port during a busy transaction, and out-of-range register addresses that must leave the bus silent.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_LEN  = 33;
  localparam int RD_HDR   = 16;
  localparam int WR_HDR   = 32;
  localparam int RD_TAIL  = 19;
  localparam int WR_TAIL  = 2;
  localparam int TA_SKIP  = 2;
  localparam int ADDR_W   = 5;
  localparam int PHY_W    = 5;
  localparam int DATA_W   = 16;
  localparam int FRAME_W  = WR_HDR;
  localparam int BIT_W    = $clog2(PRE_LEN + WR_HDR + RD_TAIL);

  typedef logic [BIT_W-1:0] bit_idx_t;

  localparam bit_idx_t PRE_END       = bit_idx_t'(PRE_LEN);
  localparam bit_idx_t RD_DRIVE_END  = bit_idx_t'(PRE_LEN + RD_HDR);
  localparam bit_idx_t WR_DRIVE_END  = bit_idx_t'(PRE_LEN + WR_HDR);
  localparam bit_idx_t RD_LAST       = bit_idx_t'(PRE_LEN + RD_HDR + RD_TAIL - 1);
  localparam bit_idx_t WR_LAST       = bit_idx_t'(PRE_LEN + WR_HDR + WR_TAIL - 1);
  localparam bit_idx_t RD_DATA_FIRST = bit_idx_t'(PRE_LEN + RD_HDR + TA_SKIP);
  localparam bit_idx_t RD_DATA_LAST  = bit_idx_t'(PRE_LEN + RD_HDR + TA_SKIP + DATA_W - 1);

  localparam logic [1:0] PAD_ONES = 2'b11;
  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RESP = 2'd2
  } eng_state_t;

endpackage

// File: rtl/mdio_halfbit_timer.sv
module mdio_halfbit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             tick
);

  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] eff_half;
  logic [DIV_W-1:0] cnt;

  assign eff_half = (half_cfg < MIN_HALF) ? MIN_HALF : half_cfg;
  assign tick     = en && !restart && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= eff_half - ONE;
    end else if (en) begin
      if (cnt == '0) cnt <= eff_half - ONE;
      else           cnt <= cnt - ONE;
    end
  end

  // R7: a half period is never shorter than two clocks
  assert_half_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int REG_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  output logic                run,
  output logic                restart,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [PHY_W-1:0]    req_phy,
  input  logic [REG_IN_W-1:0] req_reg,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                sin,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                busy,
  output logic                mdc,
  output logic                mdio_o,
  output logic                mdio_oe
);

  eng_state_t          state;
  logic                is_wr;
  logic                hi;
  logic [FRAME_W-1:0]  frame;
  logic [DATA_W-1:0]   acc;
  bit_idx_t            bit_idx, drive_end, last_idx, nb;
  logic                addr_bad, hdr_bit, in_data_win;
  logic                mdc_q, o_q, oe_q;
  logic [DATA_W-1:0]   rdata_q;

  generate
    if (REG_IN_W > ADDR_W) begin : g_range_chk
      assign addr_bad = |req_reg[REG_IN_W-1:ADDR_W];
    end else begin : g_no_range_chk
      assign addr_bad = 1'b0;
    end
  endgenerate

  assign nb          = bit_idx + bit_idx_t'(1);
  assign hdr_bit     = (bit_idx >= PRE_END) ? frame[FRAME_W-2] : frame[FRAME_W-1];
  assign in_data_win = !is_wr && (bit_idx >= RD_DATA_FIRST) && (bit_idx <= RD_DATA_LAST);
  assign restart     = (state == ST_IDLE) && req_valid;
  assign run         = (state == ST_RUN);
  assign busy        = (state != ST_IDLE);
  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_rdata   = rdata_q;
  assign mdc         = mdc_q;
  assign mdio_o      = o_q;
  assign mdio_oe     = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      hi        <= 1'b0;
      frame     <= '0;
      acc       <= '0;
      bit_idx   <= '0;
      drive_end <= '0;
      last_idx  <= '0;
      mdc_q     <= 1'b0;
      o_q       <= 1'b1;
      oe_q      <= 1'b0;
      rdata_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            is_wr <= req_write;
            if (addr_bad) begin
              state   <= ST_RESP;
              rdata_q <= req_write ? '0 : '1;
            end else begin
              state    <= ST_RUN;
              bit_idx  <= '0;
              hi       <= 1'b0;
              mdc_q    <= 1'b0;
              o_q      <= 1'b1;
              oe_q     <= 1'b1;
              acc      <= '0;
              if (req_write) begin
                frame     <= {SOF_CODE, OP_WRITE, req_phy, req_reg[ADDR_W-1:0], TA_WRITE, req_wdata};
                drive_end <= WR_DRIVE_END;
                last_idx  <= WR_LAST;
              end else begin
                frame     <= {PAD_ONES, SOF_CODE, OP_READ, req_phy, req_reg[ADDR_W-1:0], {DATA_W{1'b0}}};
                drive_end <= RD_DRIVE_END;
                last_idx  <= RD_LAST;
              end
            end
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (!hi) begin
              hi    <= 1'b1;
              mdc_q <= 1'b1;
              if (in_data_win) acc <= {acc[DATA_W-2:0], sin};
            end else begin
              hi    <= 1'b0;
              mdc_q <= 1'b0;
              if (bit_idx == last_idx) begin
                state   <= ST_RESP;
                oe_q    <= 1'b0;
                o_q     <= 1'b1;
                rdata_q <= is_wr ? '0 : acc;
              end else begin
                bit_idx <= nb;
                if (bit_idx >= PRE_END) frame <= {frame[FRAME_W-2:0], 1'b0};
                oe_q <= (nb < drive_end);
                if (nb < PRE_END)        o_q <= 1'b1;
                else if (nb < drive_end) o_q <= hdr_bit;
                else                     o_q <= 1'b1;
              end
            end
          end
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: idle bus is quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!mdc_q && !oe_q));

  // R2: preamble periods drive ones
  assert_preamble_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && bit_idx < PRE_END) |-> (oe_q && o_q));

  // R5 and R6: line released after the driven part
  assert_released_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && bit_idx >= drive_end) |-> !oe_q);

  // R7: data and enable move only on the falling MDC edge
  assert_change_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_RUN && (!$stable(o_q) || !$stable(oe_q)))
      |-> $fell(mdc_q));

  // R8: refused request answers next cycle with the bus silent
  assert_refused_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req_valid && addr_bad) |=> (rsp_valid && !mdc_q && !oe_q));

  // R9: busy holds until the response pulse
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);

  // R10: response is one cycle long
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int REG_IN_W = 8,
  parameter int SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_half_div,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [PHY_W-1:0]    req_phy,
  input  logic [REG_IN_W-1:0] req_reg,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                busy,
  output logic                mdc,
  output logic                mdio_o,
  output logic                mdio_oe,
  input  logic                mdio_i
);

  logic tick, run, restart, sin;

  mdio_halfbit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run),
    .restart  (restart),
    .half_cfg (cfg_half_div),
    .tick     (tick)
  );

  mdio_in_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mdio_i),
    .dout  (sin)
  );

  mdio_frame_engine #(.REG_IN_W(REG_IN_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run),
    .restart   (restart),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .sin       (sin),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_half_div = 8'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [7:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  // PHY model and monitor state
  int          nrise = 0;
  int          high_clks = 0;
  int          rsp_cnt = 0;
  bit          oe_seen = 1'b0;
  bit          cur_wr = 1'b0;
  logic [15:0] cur_val = '0;
  logic        oe_log [80];
  logic        o_log  [80];

  always #4 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic [15:0] exp_rd_hdr(input logic [4:0] phy, input logic [4:0] ra);
    logic [31:0] w;
    w = (32'hF6 << 10) | (32'(phy) << 5) | 32'(ra);
    return w[15:0];
  endfunction

  function automatic logic [31:0] exp_wr_frame(input logic [4:0] phy, input logic [4:0] ra,
                                               input logic [15:0] d);
    return 32'h5002_0000 | (32'(phy) << 23) | (32'(ra) << 18) | 32'(d);
  endfunction

  function automatic int eff_half(input logic [7:0] c);
    return (c < 8'd2) ? 2 : int'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // PHY: after rise k the bench presents the value for bit period k
  always @(posedge mdc) begin
    int k;
    int j;
    if (nrise < 80) begin
      oe_log[nrise] = mdio_oe;
      o_log[nrise]  = mdio_o;
    end
    nrise++;
    k = nrise;
    #1;
    j = k - 49;
    if (!cur_wr && j >= 2 && j <= 17) mdio_i = cur_val[17 - j];
    else                              mdio_i = 1'($urandom % 2);
  end

  always @(negedge clk) begin
    if (mdc) high_clks++;
    if (mdio_oe) oe_seen = 1'b1;
  end

  always @(posedge clk) if (rsp_valid) rsp_cnt++;

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [7:0] ra,
                         input logic [15:0] wd, input logic [15:0] pv,
                         input logic [7:0] cfg, input bit spam);
    bit bad;
    bit got;
    bit ready_bad;
    int nb_exp;
    int hdr_len;
    logic [31:0] hdr;
    logic [15:0] exp_data;
    bit pre_ok, hdr_ok, tail_ok;
    bad = (ra[7:5] != 3'b000);
    ready_bad = 1'b0;
    @(negedge clk);
    cfg_half_div = cfg; cur_wr = wr; cur_val = pv;
    nrise = 0; high_clks = 0; oe_seen = 1'b0; rsp_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = ra; req_wdata = wd;
    @(negedge clk);
    if (bad) begin
      req_valid = 1'b0;
      chk(rsp_valid === 1'b1, "R8", "refused response latency", rsp_valid, 1);
      chk(rsp_rdata === (wr ? 16'h0000 : 16'hFFFF), "R8", "refused rdata", rsp_rdata,
          wr ? 16'h0000 : 16'hFFFF);
      repeat (30) @(negedge clk);
      chk(nrise == 0 && !oe_seen, "R8", "refused bus activity", nrise, 0);
      chk(rsp_cnt == 1, "R10", "refused pulse count", rsp_cnt, 1);
      return;
    end
    if (spam) begin
      req_phy = ~phy; req_write = ~wr; req_reg = 8'h03; req_wdata = ~wd;
      for (int i = 0; i < 40; i++) begin
        if (req_ready !== 1'b0 || busy !== 1'b1) ready_bad = 1'b1;
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    got = 1'b0;
    for (int w = 0; w < 3000 && !got; w++) begin
      if (rsp_valid === 1'b1) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, "R10", "response seen", got, 1);
    exp_data = wr ? 16'h0000 : pv;
    if (wr) chk(rsp_rdata === exp_data, "R6", "write rdata", rsp_rdata, exp_data);
    else    chk(rsp_rdata === exp_data, "R5", "read data", rsp_rdata, exp_data);
    if (spam) chk(!ready_bad, "R9", "ready low while busy", ready_bad, 0);
    repeat (20) @(negedge clk);
    chk(rsp_cnt == 1, "R10", "pulse count", rsp_cnt, 1);
    hdr_len = wr ? 32 : 16;
    nb_exp  = 33 + hdr_len + (wr ? 2 : 19);
    hdr     = wr ? exp_wr_frame(phy, ra[4:0], wd) : {16'h0, exp_rd_hdr(phy, ra[4:0])};
    chk(nrise == nb_exp, wr ? "R6" : "R5", "bit period count", nrise, nb_exp);
    chk(high_clks == nb_exp * eff_half(cfg), "R7", "high half length", high_clks,
        nb_exp * eff_half(cfg));
    pre_ok = 1'b1; hdr_ok = 1'b1; tail_ok = 1'b1;
    for (int i = 0; i < nb_exp && i < 80; i++) begin
      if (i < 33) begin
        if (oe_log[i] !== 1'b1 || o_log[i] !== 1'b1) pre_ok = 1'b0;
      end else if (i < 33 + hdr_len) begin
        if (oe_log[i] !== 1'b1 || o_log[i] !== hdr[hdr_len - 1 - (i - 33)]) hdr_ok = 1'b0;
      end else begin
        if (oe_log[i] !== 1'b0) tail_ok = 1'b0;
      end
    end
    chk(pre_ok, "R2", "preamble", pre_ok, 1);
    chk(hdr_ok, wr ? "R4" : "R3", "header bits", hdr_ok, 1);
    chk(tail_ok, wr ? "R6" : "R5", "released tail", tail_ok, 1);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && req_ready === 1'b1, "R1", "idle after txn",
        {mdc, mdio_oe, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && busy === 1'b0 && req_ready === 1'b1 &&
        rsp_valid === 1'b0, "R1", "reset state",
        {mdc, mdio_oe, busy, req_ready, rsp_valid}, 5'b00010);

    // directed corners
    run_txn(1'b0, 5'h1F, 8'h1F, 16'h0000, 16'hA5C3, 8'd0, 1'b0);
    run_txn(1'b1, 5'h00, 8'h00, 16'hFFFF, 16'h0000, 8'd3, 1'b0);
    run_txn(1'b0, 5'h00, 8'h00, 16'h0000, 16'h0001, 8'd1, 1'b0);
    run_txn(1'b1, 5'h15, 8'h0A, 16'h8001, 16'h0000, 8'd2, 1'b0);
    run_txn(1'b0, 5'h03, 8'h20, 16'h0000, 16'h1234, 8'd2, 1'b0);
    run_txn(1'b1, 5'h03, 8'hE1, 16'hBEEF, 16'h0000, 8'd2, 1'b0);
    run_txn(1'b0, 5'h0C, 8'h11, 16'h0000, 16'h7E81, 8'd2, 1'b1);
    run_txn(1'b1, 5'h07, 8'h04, 16'h5A5A, 16'h0000, 8'd4, 1'b1);

    // constrained random
    for (int t = 0; t < 24; t++) begin
      logic [7:0] ra;
      ra = ($urandom % 8 == 0) ? 8'($urandom % 224 + 32) : 8'($urandom % 32);
      run_txn(1'($urandom % 2), 5'($urandom % 32), ra, 16'($urandom), 16'($urandom),
              8'($urandom % 6), 1'($urandom % 4 == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule